// File: doc/BRIEF.md
# Time Base and Decrementer

This block keeps a 64-bit up-counting time base and a down-counting decrementer. Each clock cycle where the tick-enable input is high moves both counters by one step. A freeze input stops the time base. The decrementer keeps counting while the time base is frozen. Software reaches both counters through a small register port. The port has a one-cycle write strobe with a select code and 64-bit data, and a combinational read selected by its own code.

Partial writes to the time base keep the bits they do not cover. There are three of them: the low word, the high word, and the 40 bits above bit 23. The decrementer raises an interrupt line when it steps from 0 to -1. Writes also raise it immediately in three cases: a value below 3, a value with the sign bit set in level mode, and a change from non-negative to negative in edge mode. In level mode, a write of a non-negative value of 3 or more lowers a pending interrupt. The decrementer is either 32 bits wide or a configured wider width. In clamp mode, a decrementer that has passed zero reads back as 0. Interrupt delivery and clock generation sit outside this block. An acknowledge input clears the pending line.

Top module: `tbdec_core`

## Requirements
- R1: After reset the time base reads 0, the interrupt is low, and the decrementer holds 0x0000_0000_FFFF_FFFF. In 32-bit mode it reads back as 0x0000_0000_FFFF_FFFF. No interrupt is raised until a tick or a write occurs.
- R2: In a cycle with tick high, freeze low and no time-base write, the time base grows by exactly 1. With tick low it holds its value.
- R3: While freeze is high the time base holds its value under ticks. After freeze drops, counting resumes from the held value.
- R4: Write select 0 loads wr_data[31:0] into time base bits 31:0 and keeps bits 63:32. Write select 1 loads wr_data[31:0] into bits 63:32 and keeps bits 31:0.
- R5: Write select 2 loads wr_data[63:24] into time base bits 63:24 and keeps bits 23:0.
- R6: In a cycle with tick high, the decrementer decreases by 1. A decrementer write (select 3) in the same cycle wins over the tick, and the written value is stored as is.
- R7: A tick that moves the decrementer from 0 to -1 raises dec_irq on the next cycle. In edge mode, later negative steps do not raise it again.
- R8: A decrementer write whose value in the active width is unsigned-below 3 raises dec_irq in both modes.
- R9: In level mode (level_mode=1), a write with the sign bit set raises dec_irq. A write of a non-negative value of 3 or more lowers it. A tick that leaves the count negative raises dec_irq.
- R10: In edge mode (level_mode=0), a write raises dec_irq only when the new value is negative and the previous value was non-negative. A write of a non-negative value of 3 or more leaves dec_irq unchanged.
- R11: With wide_mode=0 the decrementer is 32 bits wide, its sign is bit 31, and read select 3 returns it zero-extended. With wide_mode=1 it is DEC_W bits wide, its sign is bit DEC_W-1, and it reads back sign-extended to 64 bits.
- R12: With clamp_mode=1, a decrementer whose sign bit is set reads back as 0.
- R13: irq_ack lowers dec_irq on the next cycle. A raise condition in the same cycle wins over the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable for both counters |
| freeze | input | 1 | Holds the time base |
| wide_mode | input | 1 | 1: decrementer uses DEC_W bits; 0: 32 bits |
| level_mode | input | 1 | 1: sign-level underflow; 0: edge underflow |
| clamp_mode | input | 1 | 1: negative decrementer reads as 0 |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | 0 TB low word, 1 TB high word, 2 TB bits 63:24, 3 decrementer |
| wr_data | input | 64 | Write data |
| irq_ack | input | 1 | Clears the pending decrementer interrupt |
| rd_sel | input | 2 | 0 TB low word, 1 TB high word, 2 full TB, 3 decrementer |
| rd_data | output | 64 | Read data, zero-extended words for selects 0 and 1 |
| dec_irq | output | 1 | Decrementer interrupt pending |

## Verification
A vector table applies each partial time-base write to preset patterns: mixed bytes, all zeros and all ones. This shows that each write lands in its own field and does not disturb the rest. Directed sequences count the decrementer through zero in both underflow modes and in both widths. They separate the single 0-to--1 event from later negative steps, and level-driven raises from edge-driven ones. Writes test small values (0 and 2) against 3, and non-negative to negative changes against negative to negative ones. Write-versus-tick and acknowledge-versus-raise collisions confirm the priority order.

// File: rtl/tbdec_pkg.sv
// Shared select codes and widths for the time base / decrementer block.
package tbdec_pkg;
    localparam int TB_W   = 64;  // time base width
    localparam int WORD_W = 32;  // register word width
    localparam int UP_LSB = 24;  // lowest bit replaced by an upper-field write

    typedef enum logic [1:0] {
        SEL_TB_LO = 2'd0,
        SEL_TB_HI = 2'd1,
        SEL_TB_UP = 2'd2,
        SEL_DEC   = 2'd3
    } tbdec_sel_e;
endpackage

// File: rtl/tbdec_timebase.sv
// Time base counter.
// Counts up on tick unless frozen. A partial write replaces its own field and
// keeps the other bits. A write takes priority over the tick in the same cycle.
// Assumes wr_sel is only meaningful while wr_en is high.
module tbdec_timebase
    import tbdec_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            freeze,
    input  logic            wr_en,
    input  tbdec_sel_e      wr_sel,
    input  logic [TB_W-1:0] wr_data,
    output logic [TB_W-1:0] tb_q
);
    logic [TB_W-1:0] tb_r;
    logic            tb_wr;

    // Decode a write aimed at any time-base field.
    always_comb begin
        tb_wr = wr_en && (wr_sel != SEL_DEC);
    end

    // Register update: partial writes, otherwise count when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tb_r <= '0;
        end else if (tb_wr) begin
            case (wr_sel)
                SEL_TB_LO: tb_r <= {tb_r[TB_W-1:WORD_W], wr_data[WORD_W-1:0]};
                SEL_TB_HI: tb_r <= {wr_data[WORD_W-1:0], tb_r[WORD_W-1:0]};
                default:   tb_r <= {wr_data[TB_W-1:UP_LSB], tb_r[UP_LSB-1:0]};
            endcase
        end else if (tick && !freeze) begin
            tb_r <= tb_r + 1'b1;
        end
    end

    assign tb_q = tb_r;
endmodule

// File: rtl/tbdec_decrementer.sv
// Decrementer with underflow interrupt.
// The counter is held at DEC_W bits. In 32-bit mode only bits 31:0 carry
// meaning, and writes are sign-extended from bit 31. The interrupt is raised
// by the 0 -> -1 step and by the write rules of both modes, and lowered by
// the acknowledge or, in level mode, by a non-negative write.
// Assumes 32 < DEC_W < 64.
module tbdec_decrementer #(
    parameter int DEC_W = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wide_mode,
    input  logic             level_mode,
    input  logic             dec_wr,
    input  logic [DEC_W-1:0] wr_val,
    input  logic             irq_ack,
    output logic [DEC_W-1:0] dec_q,
    output logic             irq_q
);
    localparam int NW = 32;

    logic [DEC_W-1:0] dec_r, dec_d, wr_ext, stepped;
    logic             irq_r, irq_d;
    logic             old_neg, new_neg, step_neg, cur_zero, small_wr;
    logic             step, tick_raise, wr_raise, wr_lower;

    // Classify the current value and the written value in the active width.
    always_comb begin
        wr_ext   = wide_mode ? wr_val
                             : {{(DEC_W-NW){wr_val[NW-1]}}, wr_val[NW-1:0]};
        stepped  = dec_r - 1'b1;
        old_neg  = wide_mode ? dec_r[DEC_W-1]   : dec_r[NW-1];
        new_neg  = wide_mode ? wr_val[DEC_W-1]  : wr_val[NW-1];
        step_neg = wide_mode ? stepped[DEC_W-1] : stepped[NW-1];
        cur_zero = wide_mode ? (dec_r == '0)    : (dec_r[NW-1:0] == '0);
        small_wr = wide_mode ? (wr_val < DEC_W'(3)) : (wr_val[NW-1:0] < NW'(3));
    end

    // Next count: a write wins over a tick.
    always_comb begin
        step  = tick && !dec_wr;
        dec_d = dec_wr ? wr_ext : (step ? stepped : dec_r);
    end

    // Interrupt rules: any raise beats a lower or an acknowledge.
    always_comb begin
        tick_raise = step && (level_mode ? step_neg : cur_zero);
        wr_raise   = dec_wr && (small_wr || (new_neg && (level_mode || !old_neg)));
        wr_lower   = dec_wr && level_mode && !new_neg && !small_wr;
        if (tick_raise || wr_raise)    irq_d = 1'b1;
        else if (wr_lower || irq_ack)  irq_d = 1'b0;
        else                           irq_d = irq_r;
    end

    // State registers; reset loads all ones in the 32-bit width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_r <= DEC_W'({NW{1'b1}});
            irq_r <= 1'b0;
        end else begin
            dec_r <= dec_d;
            irq_r <= irq_d;
        end
    end

    assign dec_q = dec_r;
    assign irq_q = irq_r;
endmodule

// File: rtl/tbdec_readmux.sv
// Read-back selector.
// Time-base words are zero-extended. The decrementer is zero-extended from 32
// bits or sign-extended from DEC_W bits, and forced to 0 when clamped and negative.
// Purely combinational; assumes 32 < DEC_W < 64.
module tbdec_readmux
    import tbdec_pkg::*;
#(
    parameter int DEC_W = 56
) (
    input  logic             wide_mode,
    input  logic             clamp_mode,
    input  tbdec_sel_e       rd_sel,
    input  logic [TB_W-1:0]  tb_q,
    input  logic [DEC_W-1:0] dec_q,
    output logic [TB_W-1:0]  rd_data
);
    logic            dec_neg;
    logic [TB_W-1:0] dec_view;

    // Form the decrementer view for the active width and clamp setting.
    always_comb begin
        dec_neg  = wide_mode ? dec_q[DEC_W-1] : dec_q[WORD_W-1];
        dec_view = wide_mode ? {{(TB_W-DEC_W){dec_q[DEC_W-1]}}, dec_q}
                             : {{(TB_W-WORD_W){1'b0}}, dec_q[WORD_W-1:0]};
        if (clamp_mode && dec_neg) dec_view = '0;
    end

    // Select the requested register.
    always_comb begin
        case (rd_sel)
            SEL_TB_LO: rd_data = {{(TB_W-WORD_W){1'b0}}, tb_q[WORD_W-1:0]};
            SEL_TB_HI: rd_data = {{(TB_W-WORD_W){1'b0}}, tb_q[TB_W-1:WORD_W]};
            SEL_TB_UP: rd_data = tb_q;
            default:   rd_data = dec_view;
        endcase
    end
endmodule

// File: rtl/tbdec_core.sv
// Top of the time base and decrementer block.
// Connects the time base, the decrementer and the read selector to one
// register port. Writes take effect at the clock edge, and reads are combinational.
// Assumes 32 < DEC_W < 64.
module tbdec_core
    import tbdec_pkg::*;
#(
    parameter int DEC_W = 56
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        freeze,
    input  logic        wide_mode,
    input  logic        level_mode,
    input  logic        clamp_mode,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [63:0] wr_data,
    input  logic        irq_ack,
    input  logic [1:0]  rd_sel,
    output logic [63:0] rd_data,
    output logic        dec_irq
);
    tbdec_sel_e       wsel, rsel;
    logic [TB_W-1:0]  tb_val;
    logic [DEC_W-1:0] dec_val;
    logic             dec_wr;

    // Cast select codes and decode the decrementer write.
    always_comb begin
        wsel   = tbdec_sel_e'(wr_sel);
        rsel   = tbdec_sel_e'(rd_sel);
        dec_wr = wr_en && (wsel == SEL_DEC);
    end

    tbdec_timebase u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .freeze  (freeze),
        .wr_en   (wr_en),
        .wr_sel  (wsel),
        .wr_data (wr_data),
        .tb_q    (tb_val)
    );

    tbdec_decrementer #(.DEC_W(DEC_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .wide_mode  (wide_mode),
        .level_mode (level_mode),
        .dec_wr     (dec_wr),
        .wr_val     (wr_data[DEC_W-1:0]),
        .irq_ack    (irq_ack),
        .dec_q      (dec_val),
        .irq_q      (dec_irq)
    );

    tbdec_readmux #(.DEC_W(DEC_W)) u_rd (
        .wide_mode  (wide_mode),
        .clamp_mode (clamp_mode),
        .rd_sel     (rsel),
        .tb_q       (tb_val),
        .dec_q      (dec_val),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/tbdec_checker.sv
// Property checker for tbdec_core, attached by bind.
// Relates the port stimulus to the internal counter values over time.
module tbdec_checker #(
    parameter int DEC_W = 56
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             freeze,
    input logic             wide_mode,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [63:0]      wr_data,
    input logic             irq_ack,
    input logic             dec_irq,
    input logic [63:0]      tb_val,
    input logic [DEC_W-1:0] dec_val
);
    logic dec_wr_c, tb_wr_c;

    // Decode write kinds from the port.
    always_comb begin
        dec_wr_c = wr_en && (wr_sel == 2'd3);
        tb_wr_c  = wr_en && (wr_sel != 2'd3);
    end

    a_r2_tb_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !freeze && !tb_wr_c) |=> tb_val == $past(tb_val) + 64'd1);

    a_r3_tb_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !tb_wr_c) |=> $stable(tb_val));

    a_r4_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=>
            (tb_val[63:32] == $past(tb_val[63:32]) && tb_val[31:0] == $past(wr_data[31:0])));

    a_r4_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1) |=>
            (tb_val[31:0] == $past(tb_val[31:0]) && tb_val[63:32] == $past(wr_data[31:0])));

    a_r5_up_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2) |=>
            (tb_val[23:0] == $past(tb_val[23:0]) && tb_val[63:24] == $past(wr_data[63:24])));

    a_r6_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dec_wr_c) |=> dec_val == $past(dec_val) - 1'b1);

    a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_wr_c && wide_mode) |=> dec_val == $past(wr_data[DEC_W-1:0]));

    a_r8_small_write: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_wr_c && !wide_mode && wr_data[31:0] < 32'd3) |=> dec_irq);

    a_r13_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !tick && !dec_wr_c) |=> !dec_irq);
endmodule

bind tbdec_core tbdec_checker #(.DEC_W(DEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .freeze    (freeze),
    .wide_mode (wide_mode),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .irq_ack   (irq_ack),
    .dec_irq   (dec_irq),
    .tb_val    (tb_val),
    .dec_val   (dec_val)
);

// File: tb/tbdec_core_bench.sv
// Self-checking bench for tbdec_core.
module tbdec_core_bench;
    localparam int DEC_W = 56;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, freeze = 1'b0;
    logic        wide_mode = 1'b0, level_mode = 1'b0, clamp_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [63:0] wr_data = '0;
    logic        irq_ack = 1'b0;
    logic [1:0]  rd_sel = 2'd0;
    logic [63:0] rd_data;
    logic        dec_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    tbdec_core #(.DEC_W(DEC_W)) u_tbdec_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .freeze(freeze),
        .wide_mode(wide_mode), .level_mode(level_mode), .clamp_mode(clamp_mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .irq_ack(irq_ack),
        .rd_sel(rd_sel), .rd_data(rd_data), .dec_irq(dec_irq)
    );

    // Partial time-base write vectors: op, preset value, write data, expected.
    typedef struct packed {
        logic [1:0]  op;
        logic [63:0] base;
        logic [63:0] data;
        logic [63:0] expv;
    } tbvec_t;

    localparam tbvec_t TBV [0:5] = '{
        '{2'd0, 64'h1122_3344_5566_7788, 64'hFFFF_FFFF_AAAA_BBBB, 64'h1122_3344_AAAA_BBBB}, // R4
        '{2'd1, 64'h1122_3344_5566_7788, 64'h1234_5678_9ABC_DEF0, 64'h9ABC_DEF0_5566_7788}, // R4
        '{2'd2, 64'h1122_3344_5566_7788, 64'hCAFE_BABE_DEAD_BEEF, 64'hCAFE_BABE_DE66_7788}, // R5
        '{2'd0, 64'h0000_0000_0000_0000, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF}, // R4
        '{2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'h0000_0000_FFFF_FFFF}, // R4
        '{2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'h0000_0000_00FF_FFFF}  // R5
    };

    task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic read_chk(input logic [1:0] sel, input string req, input logic [63:0] expv);
        rd_sel = sel;
        #1;
        chk64(req, rd_data, expv);
    endtask

    task automatic irq_chk(input string req, input logic expv);
        chk64(req, {63'd0, dec_irq}, {63'd0, expv});
    endtask

    // One-cycle write; returns at the falling edge after the update edge.
    task automatic do_write(input logic [1:0] sel, input logic [63:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic ack;
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        read_chk(2'd2, "R1 tb reset", 64'd0);
        read_chk(2'd3, "R1 dec reset", 64'h0000_0000_FFFF_FFFF);
        irq_chk("R1 irq reset", 1'b0);

        // R2: counting and holding
        run_ticks(5);
        read_chk(2'd2, "R2 tb after 5 ticks", 64'd5);
        repeat (3) @(negedge clk);
        read_chk(2'd0, "R2 tb holds without tick", 64'd5);

        // R3: freeze holds, resume continues
        freeze = 1'b1;
        run_ticks(4);
        read_chk(2'd2, "R3 tb frozen", 64'd5);
        freeze = 1'b0;
        run_ticks(2);
        read_chk(2'd2, "R3 tb resumed", 64'd7);

        // R4 / R5: vector table of partial writes
        for (int i = 0; i < 6; i++) begin
            do_write(2'd0, {32'd0, TBV[i].base[31:0]});
            do_write(2'd1, {32'd0, TBV[i].base[63:32]});
            do_write(TBV[i].op, TBV[i].data);
            read_chk(2'd2, (TBV[i].op == 2'd2) ? "R5 upper write" : "R4 word write", TBV[i].expv);
        end
        read_chk(2'd1, "R4 high word read", 64'h0000_0000_0000_0000);

        // R10 / R7: edge mode, 32-bit
        do_write(2'd3, 64'd10);
        irq_chk("R10 neg->pos write no raise", 1'b0);
        run_ticks(10);
        read_chk(2'd3, "R6 dec counted to zero", 64'd0);
        irq_chk("R7 no raise before underflow", 1'b0);
        run_ticks(1);
        irq_chk("R7 raise on 0 to -1", 1'b1);
        read_chk(2'd3, "R11 narrow read zero-extended", 64'h0000_0000_FFFF_FFFF);
        ack();
        irq_chk("R13 ack clears", 1'b0);
        run_ticks(1);
        irq_chk("R7 no re-raise in edge mode", 1'b0);

        // R8: small writes
        do_write(2'd3, 64'd2);
        irq_chk("R8 write 2 raises", 1'b1);
        ack();
        do_write(2'd3, 64'd3);
        irq_chk("R8 write 3 does not raise", 1'b0);
        do_write(2'd3, 64'd0);
        irq_chk("R8 write 0 raises", 1'b1);
        ack();

        // R10: edge write transitions (current value 0)
        do_write(2'd3, 64'h0000_0000_FFFF_FFF0);
        irq_chk("R10 pos->neg write raises", 1'b1);
        ack();
        do_write(2'd3, 64'h0000_0000_FFFF_FFE0);
        irq_chk("R10 neg->neg write no raise", 1'b0);
        do_write(2'd3, 64'd2);
        do_write(2'd3, 64'd100);
        irq_chk("R10 edge non-negative write keeps irq", 1'b1);
        ack();

        // R12: clamp in 32-bit mode
        do_write(2'd3, 64'h0000_0000_8000_0000);
        ack();
        clamp_mode = 1'b1;
        read_chk(2'd3, "R12 narrow negative clamps", 64'd0);
        clamp_mode = 1'b0;

        // R9: level mode
        level_mode = 1'b1;
        do_write(2'd3, 64'd100);
        irq_chk("R9 non-negative write, nothing pending", 1'b0);
        do_write(2'd3, 64'h0000_0000_8000_0000);
        irq_chk("R9 negative write raises", 1'b1);
        do_write(2'd3, 64'd50);
        irq_chk("R9 non-negative write lowers", 1'b0);
        do_write(2'd3, 64'd1);
        irq_chk("R8 level small write raises", 1'b1);
        do_write(2'd3, 64'd3);
        irq_chk("R9 write 3 lowers", 1'b0);
        run_ticks(3);
        irq_chk("R9 no raise at zero", 1'b0);
        run_ticks(1);
        irq_chk("R9 tick to negative raises", 1'b1);

        // R11 / R12: wide mode
        wide_mode = 1'b1;
        do_write(2'd3, 64'h0000_0001_0000_0000);
        read_chk(2'd3, "R11 wide positive read", 64'h0000_0001_0000_0000);
        irq_chk("R9 wide non-negative write lowers", 1'b0);
        do_write(2'd3, 64'd5);
        run_ticks(6);
        read_chk(2'd3, "R11 wide negative sign-extended", 64'hFFFF_FFFF_FFFF_FFFF);
        irq_chk("R9 wide underflow raises", 1'b1);
        clamp_mode = 1'b1;
        read_chk(2'd3, "R12 wide negative clamps", 64'd0);
        clamp_mode = 1'b0;

        // R6: write wins over tick in the same cycle, then count
        wide_mode = 1'b0; level_mode = 1'b0;
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_sel = 2'd3; wr_data = 64'd100;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        read_chk(2'd3, "R6 write beats tick", 64'd100);
        run_ticks(7);
        read_chk(2'd3, "R6 count down by 7", 64'd93);

        // R13: raise beats ack in the same cycle
        ack();
        @(negedge clk);
        irq_ack = 1'b1; wr_en = 1'b1; wr_sel = 2'd3; wr_data = 64'd1;
        @(negedge clk);
        irq_ack = 1'b0; wr_en = 1'b0;
        irq_chk("R13 raise wins over ack", 1'b1);

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule